// File: doc/BRIEF.md
# Serial Byte Receiver with Receive Queue and RTS Flow Control

This block takes an asynchronous serial line and turns each incoming character into a byte. Every character begins with a low start bit and carries eight data bits, least significant bit first. An optional parity bit follows, and then a single high stop bit. The line is oversampled 16 times per bit, and the sample rate comes from the system clock through a fixed divider. Each decoded byte is written into a 16-entry receive queue together with its own parity-error and framing-error markers. A consumer drains the queue through a valid/ready read port. `rd_valid` is high whenever the queue holds at least one byte. The head byte and its markers stay stable until a cycle in which both `rd_valid` and `rd_ready` are high, and that cycle removes the byte.

The serial side cannot be stalled. When a character completes while the queue is full, the character is thrown away and a sticky overrun flag is set. Software-style status is available as plain pins: a data-ready flag, the overrun flag, a receive interrupt and an error interrupt. The data-ready flag is cleared by a two-step handshake.

The block tells the far transmitter to pause through an active-high RTS output. When flow control is enabled, RTS rises as soon as the queue fill reaches a level chosen by a 3-bit code. RTS is also forced high whenever reception is switched off.

Top module: `uart_rx_fifo`

## Requirements
- R1: A character is a 0 start bit, eight data bits with bit 0 sent first, an optional parity bit and a 1 stop bit. Each bit is sampled once, at its 8th-of-16 sample. The byte read out equals the transmitted data.
- R2: A falling edge starts a character only if the line is still low at the middle sample of the start bit. A low pulse shorter than half a bit stores nothing.
- R3: With `parity_en`=1, the bit after the data is taken as parity. The even setting is `parity_odd`=0 and the odd setting is `parity_odd`=1. A mismatch sets `rd_parity_err` for that byte. With `parity_en`=0, no parity bit is expected and `rd_parity_err` is 0.
- R4: A stop bit sampled as 0 sets `rd_frame_err` for that byte, and the byte is still stored.
- R5: `err_irq` equals `err_irq_en` AND (head byte present with either error marker, OR `ovr_flag`).
- R6: The queue holds 16 bytes in arrival order. `fill_count` gives the number held. `rd_valid` = (`fill_count` != 0), and a byte is removed only on a cycle with `rd_valid` and `rd_ready` both high.
- R7: A character completed while `fill_count`=16 is discarded and sets `ovr_flag`. The stored bytes remain unchanged and readable. `ovr_clear` clears `ovr_flag`.
- R8: Storing a byte sets `dr_flag`. `rx_irq` equals `dr_flag` AND `rx_irq_en`.
- R9: `dr_flag` is cleared by a `dr_clear_wr` pulse only after a `dr_status_rd` pulse has seen `dr_flag`=1. A `dr_clear_wr` with no such prior read leaves the flag at 1.
- R10: With `rx_enable`=1 and `flow_en`=1, `rts` = (`fill_count` >= level). Trigger codes 0 to 7 select levels 15, 1, 4, 6, 8, 10, 12 and 14.
- R11: `rts` is 1 whenever `rx_enable`=0. With `rx_enable`=1 and `flow_en`=0, `rts` is 0.
- R12: While `rx_enable`=0, the receiver ignores the line and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idles high |
| rx_enable | input | 1 | Reception enable |
| parity_en | input | 1 | Expect a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| rts_trig | input | 3 | RTS trigger code |
| flow_en | input | 1 | Enable fill-based RTS |
| rd_valid | output | 1 | Head byte available |
| rd_ready | input | 1 | Consumer takes the head byte |
| rd_data | output | 8 | Head byte |
| rd_parity_err | output | 1 | Parity marker of head byte |
| rd_frame_err | output | 1 | Framing marker of head byte |
| fill_count | output | 5 | Bytes held ($clog2(DEPTH+1) bits) |
| dr_flag | output | 1 | Data-ready flag |
| dr_status_rd | input | 1 | Pulse: status read of the data-ready flag |
| dr_clear_wr | input | 1 | Pulse: write 0 to the data-ready flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_clear | input | 1 | Pulse: clear overrun flag |
| rx_irq_en | input | 1 | Receive interrupt enable |
| err_irq_en | input | 1 | Error interrupt enable |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |
| rts | output | 1 | Request-to-send, 1 = stop sending |

## Verification
Faults in the sample counter or the bit counter show up as rotated or shifted bytes on `rd_data`. Faults in the parity or stop decision show up as wrong markers. All of these appear on the first character after the fault, about one character time later. A queue pointer or count that drifts is exposed at once by `fill_count` and `rts`, because every trigger code is swept at every fill level. It is exposed again when the drained order differs from the send order. A broken overrun path shows up on the seventeenth character as a changed count, a missing `ovr_flag` or altered contents.

// File: rtl/urx_pkg.sv
package urx_pkg;

  localparam int DATA_BITS = 8;
  localparam int OVS       = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic                 perr;
    logic                 ferr;
    logic [DATA_BITS-1:0] data;
  } rx_entry_t;

  // fill level at which RTS asserts, per 3-bit trigger code
  function automatic int unsigned rts_threshold(input logic [2:0] code);
    if (code == 3'd0)      return 15;
    else if (code == 3'd1) return 1;
    else                   return 2 * int'(code);
  endfunction

endpackage

// File: rtl/urx_deframer.sv
module urx_deframer
  import urx_pkg::*;
#(
  parameter int CLKS_PER_SAMPLE = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_in,
  input  logic      enable,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      frame_valid,
  output rx_entry_t frame
);

  localparam int SW = $clog2(OVS);
  localparam int BW = $clog2(DATA_BITS);
  localparam logic [SW-1:0] MID_CNT  = SW'(OVS / 2 - 1);
  localparam logic [SW-1:0] FULL_CNT = SW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  logic tick;

  generate
    if (CLKS_PER_SAMPLE <= 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int DW = $clog2(CLKS_PER_SAMPLE);
      localparam logic [DW-1:0] DIV_END = DW'(CLKS_PER_SAMPLE - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (div_q == DIV_END) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DIV_END);
    end
  endgenerate

  logic [1:0] sync_q;
  logic       line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};
  end
  assign line_s = sync_q[1];

  rx_state_e            st_q;
  logic [SW-1:0]        smp_q;
  logic [BW-1:0]        bit_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 par_q;
  logic                 valid_q;
  rx_entry_t            frame_q;
  logic                 par_bad;

  assign par_bad = par_en && (((^shift_q) ^ par_q) != par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      smp_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      valid_q <= 1'b0;
      frame_q <= '0;
    end else begin
      valid_q <= 1'b0;
      if (!enable) begin
        st_q  <= ST_IDLE;
        smp_q <= '0;
      end else if (tick) begin
        case (st_q)
          ST_IDLE: begin
            if (!line_s) begin
              st_q  <= ST_START;
              smp_q <= '0;
            end
          end
          ST_START: begin
            if (smp_q == MID_CNT) begin
              smp_q <= '0;
              bit_q <= '0;
              st_q  <= line_s ? ST_IDLE : ST_DATA;
            end else begin
              smp_q <= smp_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (smp_q == FULL_CNT) begin
              smp_q   <= '0;
              shift_q <= {line_s, shift_q[DATA_BITS-1:1]};
              if (bit_q == LAST_BIT) st_q <= par_en ? ST_PAR : ST_STOP;
              else                   bit_q <= bit_q + 1'b1;
            end else begin
              smp_q <= smp_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (smp_q == FULL_CNT) begin
              smp_q <= '0;
              par_q <= line_s;
              st_q  <= ST_STOP;
            end else begin
              smp_q <= smp_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (smp_q == FULL_CNT) begin
              smp_q        <= '0;
              valid_q      <= 1'b1;
              frame_q.data <= shift_q;
              frame_q.ferr <= ~line_s;
              frame_q.perr <= par_bad;
              st_q         <= ST_IDLE;
            end else begin
              smp_q <= smp_q + 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign frame_valid = valid_q;
  assign frame       = frame_q;

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo
  import urx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_valid,
  input  rx_entry_t                    push_entry,
  input  logic                         pop,
  output logic                         stored,
  output logic                         dropped,
  output logic                         head_valid,
  output rx_entry_t                    head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_END = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  rx_entry_t     mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == PTR_END) ? '0 : p + 1'b1;
  endfunction

  assign full       = (count_q == CNT_FULL);
  assign head_valid = (count_q != '0);
  assign do_push    = push_valid && !full;
  assign dropped    = push_valid && full;
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= push_entry;
  end

  assign stored = do_push;
  assign head   = mem_q[rd_ptr_q];
  assign count  = count_q;

endmodule

// File: rtl/urx_status.sv
module urx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic stored,
  input  logic dropped,
  input  logic ovr_clear,
  input  logic dr_status_rd,
  input  logic dr_clear_wr,
  input  logic rx_irq_en,
  input  logic err_irq_en,
  input  logic head_valid,
  input  logic head_perr,
  input  logic head_ferr,
  output logic dr_flag,
  output logic ovr_flag,
  output logic rx_irq,
  output logic err_irq
);

  logic dr_q, armed_q, ovr_q, clr_ok;

  assign clr_ok = dr_clear_wr && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q    <= 1'b0;
      armed_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (stored)      dr_q <= 1'b1;
      else if (clr_ok) dr_q <= 1'b0;

      if (clr_ok)                    armed_q <= 1'b0;
      else if (dr_status_rd && dr_q) armed_q <= 1'b1;

      if (dropped)        ovr_q <= 1'b1;
      else if (ovr_clear) ovr_q <= 1'b0;
    end
  end

  assign dr_flag  = dr_q;
  assign ovr_flag = ovr_q;
  assign rx_irq   = dr_q && rx_irq_en;
  assign err_irq  = err_irq_en && ((head_valid && (head_perr || head_ferr)) || ovr_q);

endmodule

// File: rtl/urx_rts.sv
module urx_rts
  import urx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       rx_enable,
  input  logic                       flow_en,
  input  logic [2:0]                 trig_code,
  input  logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       rts
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] level;
  logic          at_level;

  assign level    = CW'(rts_threshold(trig_code));
  assign at_level = (fill >= level);
  assign rts      = !rx_enable || (flow_en && at_level);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import urx_pkg::*;
#(
  parameter int DEPTH           = 16,
  parameter int CLKS_PER_SAMPLE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_line,
  input  logic                       rx_enable,
  input  logic                       parity_en,
  input  logic                       parity_odd,
  input  logic [2:0]                 rts_trig,
  input  logic                       flow_en,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [7:0]                 rd_data,
  output logic                       rd_parity_err,
  output logic                       rd_frame_err,
  output logic [$clog2(DEPTH+1)-1:0] fill_count,
  output logic                       dr_flag,
  input  logic                       dr_status_rd,
  input  logic                       dr_clear_wr,
  output logic                       ovr_flag,
  input  logic                       ovr_clear,
  input  logic                       rx_irq_en,
  input  logic                       err_irq_en,
  output logic                       rx_irq,
  output logic                       err_irq,
  output logic                       rts
);

  logic      frm_valid, stored, dropped, head_valid;
  rx_entry_t frm, head;

  urx_deframer #(.CLKS_PER_SAMPLE(CLKS_PER_SAMPLE)) deframer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_in     (rx_line),
    .enable      (rx_enable),
    .par_en      (parity_en),
    .par_odd     (parity_odd),
    .frame_valid (frm_valid),
    .frame       (frm)
  );

  urx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (frm_valid),
    .push_entry (frm),
    .pop        (rd_ready),
    .stored     (stored),
    .dropped    (dropped),
    .head_valid (head_valid),
    .head       (head),
    .count      (fill_count)
  );

  urx_status status_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .stored       (stored),
    .dropped      (dropped),
    .ovr_clear    (ovr_clear),
    .dr_status_rd (dr_status_rd),
    .dr_clear_wr  (dr_clear_wr),
    .rx_irq_en    (rx_irq_en),
    .err_irq_en   (err_irq_en),
    .head_valid   (head_valid),
    .head_perr    (head.perr),
    .head_ferr    (head.ferr),
    .dr_flag      (dr_flag),
    .ovr_flag     (ovr_flag),
    .rx_irq       (rx_irq),
    .err_irq      (err_irq)
  );

  urx_rts #(.DEPTH(DEPTH)) rts_i (
    .rx_enable (rx_enable),
    .flow_en   (flow_en),
    .trig_code (rts_trig),
    .fill      (fill_count),
    .rts       (rts)
  );

  assign rd_valid      = head_valid;
  assign rd_data       = head.data;
  assign rd_parity_err = head.perr;
  assign rd_frame_err  = head.ferr;

endmodule

// File: rtl/urx_checker.sv
module urx_checker
  import urx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_enable,
  input logic [2:0]                 rts_trig,
  input logic                       flow_en,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic [$clog2(DEPTH+1)-1:0] fill_count,
  input logic                       dr_flag,
  input logic                       dr_clear_wr,
  input logic                       ovr_flag,
  input logic                       rx_irq_en,
  input logic                       err_irq_en,
  input logic                       rx_irq,
  input logic                       err_irq,
  input logic                       rts
);

  localparam int CW = $clog2(DEPTH + 1);

  assert_fill_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH));

  assert_fill_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fill_count) |-> (fill_count == CW'($past(fill_count) + 1'b1) ||
                              fill_count == CW'($past(fill_count) - 1'b1)));

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == CW'(DEPTH) && !(rd_valid && rd_ready)) |=> fill_count == CW'(DEPTH));

  assert_ovr_only_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(fill_count) == CW'(DEPTH));

  assert_dr_clear_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dr_flag) |-> $past(dr_clear_wr));

  assert_rx_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (dr_flag && rx_irq_en));

  assert_err_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> err_irq_en);

  assert_rts_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> rts);

  assert_rts_at_trigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && flow_en && fill_count >= CW'(rts_threshold(rts_trig))) |-> rts);

endmodule

bind uart_rx_fifo urx_checker #(.DEPTH(DEPTH)) checker_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_enable   (rx_enable),
  .rts_trig    (rts_trig),
  .flow_en     (flow_en),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .fill_count  (fill_count),
  .dr_flag     (dr_flag),
  .dr_clear_wr (dr_clear_wr),
  .ovr_flag    (ovr_flag),
  .rx_irq_en   (rx_irq_en),
  .err_irq_en  (err_irq_en),
  .rx_irq      (rx_irq),
  .err_irq     (err_irq),
  .rts         (rts)
);

// File: tb/uart_rx_fifo_tb_top.sv
`timescale 1ns/1ps
module uart_rx_fifo_tb_top;

  localparam int CPS     = 4;
  localparam int BIT_CLK = 16 * CPS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       rx_enable = 1'b0;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic [2:0] rts_trig = 3'd0;
  logic       flow_en = 1'b0;
  logic       rd_ready = 1'b0;
  logic       dr_status_rd = 1'b0;
  logic       dr_clear_wr = 1'b0;
  logic       ovr_clear = 1'b0;
  logic       rx_irq_en = 1'b0;
  logic       err_irq_en = 1'b0;
  logic       rd_valid, rd_parity_err, rd_frame_err;
  logic [7:0] rd_data;
  logic [4:0] fill_count;
  logic       dr_flag, ovr_flag, rx_irq, err_irq, rts;

  int n_cmp = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_fifo #(.DEPTH(16), .CLKS_PER_SAMPLE(CPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_enable(rx_enable),
    .parity_en(parity_en), .parity_odd(parity_odd), .rts_trig(rts_trig),
    .flow_en(flow_en), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_parity_err(rd_parity_err), .rd_frame_err(rd_frame_err),
    .fill_count(fill_count), .dr_flag(dr_flag), .dr_status_rd(dr_status_rd),
    .dr_clear_wr(dr_clear_wr), .ovr_flag(ovr_flag), .ovr_clear(ovr_clear),
    .rx_irq_en(rx_irq_en), .err_irq_en(err_irq_en), .rx_irq(rx_irq),
    .err_irq(err_irq), .rts(rts)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic b, input int n);
    rx_line = b;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cycle1;
    @(posedge clk);
    #1;
  endtask

  // pmode: 0 no parity bit, 1 correct parity, 2 wrong parity
  task automatic send(input logic [7:0] d, input int pmode, input logic stop_ok);
    logic pb;
    pb = (^d) ^ parity_odd;
    if (pmode == 2) pb = ~pb;
    cycle1();
    hold(1'b0, BIT_CLK);
    for (int i = 0; i < 8; i++) hold(d[i], BIT_CLK);
    if (pmode != 0) hold(pb, BIT_CLK);
    if (stop_ok) hold(1'b1, BIT_CLK);
    else begin
      hold(1'b0, 44);
      hold(1'b1, BIT_CLK - 44);
    end
    hold(1'b1, 2 * BIT_CLK);
  endtask

  task automatic pop_chk(input string req, input logic [7:0] d, input logic pe, input logic fe);
    chk({req, " rd_valid"}, int'(rd_valid), 1);
    chk({req, " rd_data"}, int'(rd_data), int'(d));
    chk({req, " parity marker"}, int'(rd_parity_err), int'(pe));
    chk({req, " frame marker"}, int'(rd_frame_err), int'(fe));
    rd_ready = 1'b1;
    cycle1();
    rd_ready = 1'b0;
  endtask

  function automatic int lvl(input int code);
    if (code == 0) return 15;
    if (code == 1) return 1;
    return 2 * code;
  endfunction

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] pat [8];
    pat = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h7E, 8'h01, 8'h80};
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    cycle1();
    // reset state
    chk("R11 rts after reset, rx off", int'(rts), 1);
    chk("R6 fill after reset", int'(fill_count), 0);
    chk("R6 rd_valid after reset", int'(rd_valid), 0);
    chk("R8 dr_flag after reset", int'(dr_flag), 0);
    chk("R5 err_irq after reset", int'(err_irq), 0);

    // R12: receiver off ignores the line
    send(8'h5A, 0, 1'b1);
    chk("R12 nothing stored while off", int'(fill_count), 0);

    rx_enable = 1'b1;
    cycle1();
    chk("R11 rts low with flow off", int'(rts), 0);

    // R1/R6: data patterns, order kept
    foreach (pat[i]) send(pat[i], 0, 1'b1);
    chk("R6 fill after 8 bytes", int'(fill_count), 8);
    chk("R8 dr_flag set", int'(dr_flag), 1);
    chk("R8 rx_irq masked", int'(rx_irq), 0);
    rx_irq_en = 1'b1;
    cycle1();
    chk("R8 rx_irq enabled", int'(rx_irq), 1);

    // R9: clear handshake
    dr_clear_wr = 1'b1; cycle1(); dr_clear_wr = 1'b0; cycle1();
    chk("R9 write0 without read ignored", int'(dr_flag), 1);
    dr_status_rd = 1'b1; cycle1(); dr_status_rd = 1'b0; cycle1();
    dr_clear_wr = 1'b1; cycle1(); dr_clear_wr = 1'b0; cycle1();
    chk("R9 read then write0 clears", int'(dr_flag), 0);
    chk("R8 rx_irq follows flag", int'(rx_irq), 0);

    foreach (pat[i]) pop_chk("R1", pat[i], 1'b0, 1'b0);
    chk("R6 drained", int'(rd_valid), 0);

    // R3/R5: parity sweep
    parity_en  = 1'b1;
    err_irq_en = 1'b1;
    for (int odd = 0; odd < 2; odd++) begin
      for (int bad = 0; bad < 2; bad++) begin
        logic [7:0] d;
        parity_odd = odd[0];
        d = 8'h6B ^ 8'(odd * 16 + bad * 3);
        send(d, bad + 1, 1'b1);
        chk("R5 err_irq on parity", int'(err_irq), bad);
        pop_chk("R3", d, bad[0], 1'b0);
      end
    end
    parity_en = 1'b0;

    // R4: stop bit sampled low
    send(8'hC3, 0, 1'b0);
    chk("R4 single byte stored", int'(fill_count), 1);
    chk("R5 err_irq on framing", int'(err_irq), 1);
    pop_chk("R4", 8'hC3, 1'b0, 1'b1);
    chk("R5 err_irq clear after pop", int'(err_irq), 0);

    // R2: short low pulse
    cycle1();
    hold(1'b0, 12);
    hold(1'b1, 3 * BIT_CLK);
    chk("R2 glitch stores nothing", int'(fill_count), 0);

    // R10: trigger sweep at every fill level
    flow_en = 1'b1;
    for (int n = 1; n <= 16; n++) begin
      send(8'(n * 7), 0, 1'b1);
      chk("R6 fill count", int'(fill_count), n);
      for (int c = 0; c < 8; c++) begin
        rts_trig = 3'(c);
        #1;
        chk("R10 rts vs trigger", int'(rts), int'(n >= lvl(c)));
      end
    end
    flow_en = 1'b0;
    #1;
    chk("R11 rts low with flow off, full", int'(rts), 0);
    flow_en = 1'b1;
    rx_enable = 1'b0;
    #1;
    chk("R11 rts high when rx off", int'(rts), 1);
    rx_enable = 1'b1;
    cycle1();

    // R7: overrun
    chk("R7 no overrun before", int'(ovr_flag), 0);
    send(8'hEE, 0, 1'b1);
    chk("R7 fill stays full", int'(fill_count), 16);
    chk("R7 overrun flag", int'(ovr_flag), 1);
    chk("R5 err_irq on overrun", int'(err_irq), 1);
    for (int n = 1; n <= 16; n++) pop_chk("R7", 8'(n * 7), 1'b0, 1'b0);
    chk("R7 empty after drain", int'(fill_count), 0);
    ovr_clear = 1'b1; cycle1(); ovr_clear = 1'b0; cycle1();
    chk("R7 overrun cleared", int'(ovr_flag), 0);

    done = 1'b1;
    finish_run();
  end

endmodule